// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Register

The block holds two single-word mailboxes that pass control words between two ports running on unrelated clocks, beside the data queue and not through it. Mailbox one is loaded from port A and read out on port B. Mailbox two is loaded from port B and read out on port A. Each port has a chip select, a direction input (high to write, low to read), an enable, and a mailbox select that routes the port's transfer to the mailbox instead of the queue.

Each mailbox has an active-low full flag that lives in the clock domain of the port that loads it. A load is accepted only while the flag is high, and the flag then drops. A read on the far port acknowledges the word: the acknowledge crosses back through a toggle handshake and a two-stage synchronizer and raises the flag again. A read leaves the stored word unchanged. A shared bus-size mode limits the used width of both mailboxes to 36, 18 or 9 bits. Each port's read-data output shows the mailbox when its mailbox select is high and the queue's output register when it is low.

Top module: `mbx_bypass`

## Requirements
- R1: While reset is held and after it is released, both full flags are high and both mailboxes read as zero.
- R2: A port A rising edge with chip select, write direction, enable and mailbox select all high loads mailbox one and drops `a_full_n` after that edge. The word then appears on `b_rdata` while `b_mbx` is high.
- R3: A port A cycle with enable low, or with mailbox select low, loads nothing and leaves `a_full_n` high.
- R4: While a full flag is low, write attempts to that mailbox are ignored and the stored word does not change.
- R5: A port B read (chip select, enable and mailbox select high, direction low) of a full mailbox one raises `a_full_n` within a few port A cycles. The flag stays low until such a read happens.
- R6: The stored word stays the same after it is read and changes only when a later load is accepted.
- R7: `bus_mode` 2'b00 (and 2'b11) uses 36 bits, 2'b01 uses bits 17:0, and 2'b10 uses bits 8:0. Input bits above the used width are dropped on a load, and bits above the used width read as zero on output.
- R8: With its mailbox select low, a port's read data equals that port's queue output-register input.
- R9: Mailbox two works the same way in the opposite direction: it is loaded from port B, `b_full_n` is its flag, and it is read and acknowledged on port A.
- R10: After an acknowledge has raised the flag, the next load is accepted and replaces the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_mode | input | 2 | Used-width select: 00 or 11 = 36 bits, 01 = 18 bits, 10 = 9 bits |
| a_cs | input | 1 | Port A chip select |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_en | input | 1 | Port A enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_wdata | input | 36 | Port A write data |
| a_fifo_q | input | 36 | Port A queue output-register data |
| a_rdata | output | 36 | Port A read data |
| a_full_n | output | 1 | Mailbox one full flag, active low, port A domain |
| b_cs | input | 1 | Port B chip select |
| b_wr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_en | input | 1 | Port B enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_wdata | input | 36 | Port B write data |
| b_fifo_q | input | 36 | Port B queue output-register data |
| b_rdata | output | 36 | Port B read data |
| b_full_n | output | 1 | Mailbox two full flag, active low, port B domain |

## Verification
The bench builds the block with its default widths: 36 bits in full, 18 in the middle mode and 9 in the narrow mode. All three lane masks are therefore exercised on both the load path and the output path. Port A runs at 10 ns and port B at 14 ns, so the handshake synchronizers see edges that drift against each other. Under these settings, a flag round trip, a blocked load, and a narrow-mode read of a word stored in full width are all exercised.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    BUS_FULL  = 2'b00,
    BUS_HALF  = 2'b01,
    BUS_NINTH = 2'b10,
    BUS_RSVD  = 2'b11
  } bus_mode_e;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_sync2.sv
module mbx_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], din};
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int W      = 36,
  parameter int STAGES = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  input  logic         rd_req,
  output logic         full_n,
  output logic [W-1:0] mail
);
  // writer domain
  logic [W-1:0] data_q, data_d;
  logic         wtgl_q, wtgl_d;
  logic         rtgl_w;
  logic         wr_ok;
  // reader domain
  logic         rtgl_q, rtgl_d;
  logic         wtgl_r;
  logic         pending;

  mbx_sync2 #(.STAGES(STAGES)) u_ack_sync (
    .clk(wclk), .rst_n(wrst_n), .din(rtgl_q), .dout(rtgl_w)
  );

  mbx_sync2 #(.STAGES(STAGES)) u_req_sync (
    .clk(rclk), .rst_n(rrst_n), .din(wtgl_q), .dout(wtgl_r)
  );

  assign full_n = (wtgl_q == rtgl_w);
  assign wr_ok  = wr_req & full_n;

  always_comb begin
    data_d = data_q;
    wtgl_d = wtgl_q;
    if (wr_ok) begin
      data_d = wdata;
      wtgl_d = ~wtgl_q;
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      data_q <= '0;
      wtgl_q <= 1'b0;
    end else begin
      data_q <= data_d;
      wtgl_q <= wtgl_d;
    end
  end

  assign pending = (wtgl_r != rtgl_q);

  always_comb begin
    rtgl_d = rtgl_q;
    if (rd_req && pending) rtgl_d = ~rtgl_q;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rtgl_q <= 1'b0;
    else         rtgl_q <= rtgl_d;
  end

  assign mail = data_q;
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass
  import mbx_pkg::*;
#(
  parameter int W      = 36,
  parameter int W_MID  = 18,
  parameter int W_LOW  = 9,
  parameter int STAGES = 2
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         arst_n,
  input  logic [1:0]   bus_mode,
  input  logic         a_cs,
  input  logic         a_wr,
  input  logic         a_en,
  input  logic         a_mbx,
  input  logic [W-1:0] a_wdata,
  input  logic [W-1:0] a_fifo_q,
  output logic [W-1:0] a_rdata,
  output logic         a_full_n,
  input  logic         b_cs,
  input  logic         b_wr,
  input  logic         b_en,
  input  logic         b_mbx,
  input  logic [W-1:0] b_wdata,
  input  logic [W-1:0] b_fifo_q,
  output logic [W-1:0] b_rdata,
  output logic         b_full_n
);
  bus_mode_e    mode;
  int           lim;
  logic [W-1:0] lane_mask;
  logic         rst_a_n, rst_b_n;
  logic         a_wr_req, a_rd_req, b_wr_req, b_rd_req;
  logic [W-1:0] mail1, mail2;

  assign mode = bus_mode_e'(bus_mode);

  always_comb begin
    case (mode)
      BUS_HALF:  lim = W_MID;
      BUS_NINTH: lim = W_LOW;
      default:   lim = W;
    endcase
    for (int i = 0; i < W; i++) lane_mask[i] = (i < lim);
  end

  mbx_rst_sync #(.STAGES(STAGES)) u_rst_a (.clk(clk_a), .arst_n(arst_n), .rst_n(rst_a_n));
  mbx_rst_sync #(.STAGES(STAGES)) u_rst_b (.clk(clk_b), .arst_n(arst_n), .rst_n(rst_b_n));

  assign a_wr_req = a_cs &  a_wr & a_en & a_mbx;
  assign a_rd_req = a_cs & ~a_wr & a_en & a_mbx;
  assign b_wr_req = b_cs &  b_wr & b_en & b_mbx;
  assign b_rd_req = b_cs & ~b_wr & b_en & b_mbx;

  mbx_channel #(.W(W), .STAGES(STAGES)) u_mail1 (
    .wclk(clk_a), .wrst_n(rst_a_n), .rclk(clk_b), .rrst_n(rst_b_n),
    .wr_req(a_wr_req), .wdata(a_wdata & lane_mask), .rd_req(b_rd_req),
    .full_n(a_full_n), .mail(mail1)
  );

  mbx_channel #(.W(W), .STAGES(STAGES)) u_mail2 (
    .wclk(clk_b), .wrst_n(rst_b_n), .rclk(clk_a), .rrst_n(rst_a_n),
    .wr_req(b_wr_req), .wdata(b_wdata & lane_mask), .rd_req(a_rd_req),
    .full_n(b_full_n), .mail(mail2)
  );

  assign a_rdata = a_mbx ? (mail2 & lane_mask) : a_fifo_q;
  assign b_rdata = b_mbx ? (mail1 & lane_mask) : b_fifo_q;
endmodule

// File: rtl/mbx_bypass_chk.sv
module mbx_bypass_chk #(
  parameter int W      = 36,
  parameter int W_MID  = 18,
  parameter int W_LOW  = 9,
  parameter int STAGES = 2
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         arst_n,
  input logic [1:0]   bus_mode,
  input logic         a_cs,
  input logic         a_wr,
  input logic         a_en,
  input logic         a_mbx,
  input logic [W-1:0] a_fifo_q,
  input logic [W-1:0] a_rdata,
  input logic         a_full_n,
  input logic         b_cs,
  input logic         b_wr,
  input logic         b_en,
  input logic         b_mbx,
  input logic [W-1:0] b_rdata,
  input logic         b_full_n
);
  AST_MAIL1_FALL_NEEDS_LOAD: assert property (@(posedge clk_a) disable iff (!arst_n)
    $fell(a_full_n) |-> $past(a_cs && a_wr && a_en && a_mbx)); // R2

  AST_MAIL2_FALL_NEEDS_LOAD: assert property (@(posedge clk_b) disable iff (!arst_n)
    $fell(b_full_n) |-> $past(b_cs && b_wr && b_en && b_mbx)); // R9

  AST_NINTH_UPPER_ZERO: assert property (@(posedge clk_a) disable iff (!arst_n)
    (bus_mode == 2'b10 && a_mbx) |-> (a_rdata >> W_LOW) == '0); // R7

  AST_HALF_UPPER_ZERO: assert property (@(posedge clk_b) disable iff (!arst_n)
    (bus_mode == 2'b01 && b_mbx) |-> (b_rdata >> W_MID) == '0); // R7

  AST_QUEUE_PASS: assert property (@(posedge clk_a) disable iff (!arst_n)
    !a_mbx |-> a_rdata == a_fifo_q); // R8
endmodule

bind mbx_bypass mbx_bypass_chk #(.W(W), .W_MID(W_MID), .W_LOW(W_LOW), .STAGES(STAGES)) u_chk (.*);

// File: tb/mbx_bypass_tb.sv
module mbx_bypass_tb;
  localparam int W = 36;

  logic         clk_a = 1'b0, clk_b = 1'b0, arst_n = 1'b0;
  logic [1:0]   bus_mode = 2'b00;
  logic         a_cs = 0, a_wr = 0, a_en = 0, a_mbx = 0;
  logic         b_cs = 0, b_wr = 0, b_en = 0, b_mbx = 0;
  logic [W-1:0] a_wdata = '0, a_fifo_q = '0, b_wdata = '0, b_fifo_q = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic         a_full_n, b_full_n;
  int           n_chk = 0, n_bad = 0;

  always #5 clk_a = ~clk_a;
  always #7 clk_b = ~clk_b;

  mbx_bypass u_dut (.*);

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_cycle(logic cs, logic wr, logic en, logic mbx, logic [W-1:0] d);
    @(negedge clk_a);
    a_cs = cs; a_wr = wr; a_en = en; a_mbx = mbx; a_wdata = d;
    @(negedge clk_a);
    a_cs = 0; a_wr = 0; a_en = 0; a_wdata = '0;
  endtask

  task automatic b_cycle(logic cs, logic wr, logic en, logic mbx, logic [W-1:0] d);
    @(negedge clk_b);
    b_cs = cs; b_wr = wr; b_en = en; b_mbx = mbx; b_wdata = d;
    @(negedge clk_b);
    b_cs = 0; b_wr = 0; b_en = 0; b_wdata = '0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk_a);
    repeat (6) @(negedge clk_b);
  endtask

  task automatic t_reset();
    a_mbx = 1; b_mbx = 1;
    @(negedge clk_a);
    check("R1 flag a", W'(a_full_n), W'(1'b1));
    check("R1 flag b", W'(b_full_n), W'(1'b1));
    check("R1 mail2 zero", a_rdata, '0);
    check("R1 mail1 zero", b_rdata, '0);
  endtask

  task automatic t_queue_mux();
    a_mbx = 0; b_mbx = 0;
    a_fifo_q = 36'h1_2345_6789; b_fifo_q = 36'hE_DCBA_9876;
    @(negedge clk_a);
    check("R8 port a queue", a_rdata, 36'h1_2345_6789);
    @(negedge clk_b);
    check("R8 port b queue", b_rdata, 36'hE_DCBA_9876);
    b_mbx = 1;
  endtask

  task automatic t_ignored();
    a_cycle(1, 1, 0, 1, 36'hF_0000_000F);
    a_cycle(1, 1, 1, 0, 36'hF_0000_00F0);
    settle();
    check("R3 flag stays high", W'(a_full_n), W'(1'b1));
    check("R3 mail1 untouched", b_rdata, '0);
  endtask

  task automatic t_load_and_block();
    a_cycle(1, 1, 1, 1, 36'h9_A5A5_C3C3);
    check("R2 flag low", W'(a_full_n), W'(1'b0));
    settle();
    check("R2 mail1 seen on b", b_rdata, 36'h9_A5A5_C3C3);
    a_cycle(1, 1, 1, 1, 36'h0_1111_2222);
    settle();
    check("R4 flag still low", W'(a_full_n), W'(1'b0));
    check("R4 word kept", b_rdata, 36'h9_A5A5_C3C3);
  endtask

  task automatic t_read_ack(logic [W-1:0] exp, string req);
    b_cycle(1, 0, 1, 1, '0);
    check(req, b_rdata, exp);
    settle();
    check("R5 flag high after read", W'(a_full_n), W'(1'b1));
    check("R6 word persists", b_rdata, exp);
  endtask

  task automatic t_mail2();
    b_cycle(1, 1, 1, 1, 36'h3_0F0F_F0F0);
    check("R9 mail2 flag low", W'(b_full_n), W'(1'b0));
    a_mbx = 1;
    settle();
    check("R9 mail2 seen on a", a_rdata, 36'h3_0F0F_F0F0);
    a_cycle(1, 0, 1, 1, '0);
    settle();
    check("R9 mail2 flag high", W'(b_full_n), W'(1'b1));
  endtask

  task automatic t_reload();
    a_cycle(1, 1, 1, 1, 36'h5_5555_AAAA);
    check("R10 flag low again", W'(a_full_n), W'(1'b0));
    settle();
    check("R10 new word", b_rdata, 36'h5_5555_AAAA);
    t_read_ack(36'h5_5555_AAAA, "R6 read new word");
  endtask

  task automatic t_narrow();
    bus_mode = 2'b10;
    settle();
    check("R7 ninth output mask", a_rdata, 36'h0_0000_00F0);
    a_cycle(1, 1, 1, 1, 36'hF_FFFF_FFFF);
    settle();
    check("R7 ninth load", b_rdata, 36'h0_0000_01FF);
    t_read_ack(36'h0_0000_01FF, "R7 ninth read");
    bus_mode = 2'b01;
    a_cycle(1, 1, 1, 1, 36'hF_FFFF_FFFF);
    settle();
    check("R7 half load", b_rdata, 36'h0_0003_FFFF);
    bus_mode = 2'b00;
    settle();
    check("R7 full mode shows stored", b_rdata, 36'h0_0003_FFFF);
    t_read_ack(36'h0_0003_FFFF, "R7 half read");
  endtask

  initial begin
    repeat (100000) @(posedge clk_a);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_a);
    arst_n = 1'b1;
    settle();
    t_reset();
    t_queue_mux();
    t_ignored();
    t_load_and_block();
    t_read_ack(36'h9_A5A5_C3C3, "R5 read data");
    t_mail2();
    t_reload();
    t_narrow();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule